// File: doc/BRIEF.md
# Masked-write GPIO port register block

This block holds the control state of one eight-pin GPIO port and presents it on a simple word-wide register bus. Three writable registers control the pins. The pin-select register decides whether each pad is owned by the GPIO logic or is left to its alternate function. The drive-enable register turns each pin's output driver on or off. The drive-value register holds the level each driven pin presents. A fourth, read-only register returns the pad levels after they pass through a two-flop synchronizer.

Each writable register can be reached at two addresses. A write to the whole-word alias replaces all eight bits. A write to the masked alias changes only the pins named in the upper byte of the write data. Software can therefore flip one pin in a single bus write, with no read-modify-write and no race against another agent that updates a different pin of the same port.

The address map is built from parameters. These are a base address, the port's slot within its group (slot size four bytes), a group spacing, and the distance from each whole-word alias to its masked alias. The pad outputs go to a pad ring or pin multiplexer that lies outside this block.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset the pin-select, drive-enable and drive-value registers are all zero, `pad_gpio_sel` and `pad_oe` are zero, and every control address reads back zero.
- R2: A bus write to a whole-word alias loads bits 7:0 of `bus_wdata` into the register, ignoring all higher bits. The new value is readable from the next clock cycle.
- R3: In a bus write to a masked alias, pin n takes `bus_wdata[n]` when `bus_wdata[8+n]` is 1. When `bus_wdata[8+n]` is 0, pin n keeps its value.
- R4: A read of either alias of a register returns its 8-bit value in bits 7:0, with all higher bits zero. Reads are combinational from `bus_addr`.
- R5: The whole-word aliases are at BASE + PORT_SEL*4 plus a group offset. The groups are pin-select at 0x00, drive-enable at 0x10, drive-value at 0x20 and pad input at 0x30. The masked aliases are at the whole-word address plus MASK_OFS (default 0x80). With the defaults (BASE 0, PORT_SEL 1) the addresses are 0x04, 0x14, 0x24, 0x34, 0x84, 0x94 and 0xA4.
- R6: `pad_gpio_sel[n]` is 1 exactly when pin-select bit n is 1. A zero bit leaves the pad to its alternate function.
- R7: `pad_oe[n]` is 1 only when both pin-select bit n and drive-enable bit n are 1. `pad_out` follows the drive-value register.
- R8: The pad-input register returns `pad_in` delayed by two clock edges.
- R9: Writes to the pad-input address leave every register unchanged, and the read value still follows the pads.
- R10: Writes to an address outside the map change nothing. This includes other ports' slots and the masked slot of the input group. Such addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` |
| pad_in | input | PINS | Raw pad levels |
| pad_out | output | PINS | Drive value to the pads |
| pad_oe | output | PINS | Per-pin driver enable |
| pad_gpio_sel | output | PINS | Per-pin GPIO ownership, 0 = alternate function |

## Verification
A write is captured at the first rising edge after `bus_wr` is raised. Its effect on `bus_rdata` and the pad outputs is therefore due one edge later. The bench drives at a falling edge and reads at the next falling edge, half a period after the capture. A change on `pad_in` is due on the input register two rising edges later. The bench confirms that the old value is still present after one edge and the new value after the second, sampling each time at a falling edge. The read path has no register, so reads are sampled one time step after the address is set.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    typedef enum logic [2:0] {
        SEL_CNF  = 3'd0,
        SEL_OE   = 3'd1,
        SEL_OUT  = 3'd2,
        SEL_IN   = 3'd3,
        SEL_NONE = 3'd4
    } reg_sel_e;

    localparam int NUM_CTRL   = 3;
    localparam int NUM_GROUPS = 4;

endpackage

// File: rtl/gpio_port_decode.sv
module gpio_port_decode
    import gpio_port_pkg::*;
#(
    parameter int ADDR_W       = 12,
    parameter int BASE         = 0,
    parameter int PORT_SEL     = 1,
    parameter int SLOT_BYTES   = 4,
    parameter int GROUP_STRIDE = 16,
    parameter int MASK_OFS     = 128
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic              masked
);

    localparam int PORT_BASE = BASE + PORT_SEL * SLOT_BYTES;

    always_comb begin
        sel    = SEL_NONE;
        masked = 1'b0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (addr == ADDR_W'(PORT_BASE + g * GROUP_STRIDE)) begin
                sel    = reg_sel_e'(g);
                masked = 1'b0;
            end
            if (g < NUM_CTRL &&
                addr == ADDR_W'(PORT_BASE + g * GROUP_STRIDE + MASK_OFS)) begin
                sel    = reg_sel_e'(g);
                masked = 1'b1;
            end
        end
    end

endmodule

// File: rtl/gpio_ctrl_reg.sv
module gpio_ctrl_reg #(
    parameter int PINS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            plain_we,
    input  logic            mask_we,
    input  logic [PINS-1:0] wval,
    input  logic [PINS-1:0] wmask,
    output logic [PINS-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (plain_we) begin
            q <= wval;
        end else if (mask_we) begin
            q <= (q & ~wmask) | (wval & wmask);
        end
    end

    // R2: a whole-word write lands in full
    p_plain_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        plain_we |=> q == $past(wval));

    // R3: pins outside the mask keep their value
    p_mask_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_we && !plain_we) |=> (q & ~$past(wmask)) == ($past(q) & ~$past(wmask)));

    // R3: pins inside the mask take the new value
    p_mask_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_we && !plain_we) |=> (q & $past(wmask)) == ($past(wval) & $past(wmask)));

    // R10: with no write the register holds
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!mask_we && !plain_we) |=> $stable(q));

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int PINS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] d,
    output logic [PINS-1:0] q
);

    logic [PINS-1:0] stage1;
    logic [1:0]      warm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warm <= '0;
        end else if (warm != 2'd3) begin
            warm <= warm + 2'd1;
        end
    end

    // R8: input value lags the pads by two edges
    p_sync_lag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3) |-> q == $past(d, 2));

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int PINS         = 8,
    parameter int DATA_W       = 32,
    parameter int ADDR_W       = 12,
    parameter int BASE         = 0,
    parameter int PORT_SEL     = 1,
    parameter int SLOT_BYTES   = 4,
    parameter int GROUP_STRIDE = 16,
    parameter int MASK_OFS     = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [PINS-1:0]   pad_in,
    output logic [PINS-1:0]   pad_out,
    output logic [PINS-1:0]   pad_oe,
    output logic [PINS-1:0]   pad_gpio_sel
);

    localparam int MASK_LO = PINS;
    localparam int MASK_HI = 2 * PINS - 1;

    reg_sel_e        sel;
    logic            masked;
    logic [PINS-1:0] ctrl_q [NUM_CTRL];
    logic [NUM_CTRL-1:0] plain_we_v;
    logic [NUM_CTRL-1:0] mask_we_v;
    logic [PINS-1:0] in_q;
    logic            unused_hi;

    assign unused_hi = ^bus_wdata[DATA_W-1:MASK_HI+1];

    gpio_port_decode #(
        .ADDR_W      (ADDR_W),
        .BASE        (BASE),
        .PORT_SEL    (PORT_SEL),
        .SLOT_BYTES  (SLOT_BYTES),
        .GROUP_STRIDE(GROUP_STRIDE),
        .MASK_OFS    (MASK_OFS)
    ) u_decode (
        .addr  (bus_addr),
        .sel   (sel),
        .masked(masked)
    );

    for (genvar i = 0; i < NUM_CTRL; i++) begin : g_ctrl
        assign plain_we_v[i] = bus_wr && (sel == reg_sel_e'(i)) && !masked;
        assign mask_we_v[i]  = bus_wr && (sel == reg_sel_e'(i)) && masked;

        gpio_ctrl_reg #(.PINS(PINS)) u_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .plain_we(plain_we_v[i]),
            .mask_we (mask_we_v[i]),
            .wval    (bus_wdata[PINS-1:0]),
            .wmask   (bus_wdata[MASK_HI:MASK_LO]),
            .q       (ctrl_q[i])
        );
    end

    gpio_in_sync #(.PINS(PINS)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pad_in),
        .q    (in_q)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            SEL_CNF:  bus_rdata[PINS-1:0] = ctrl_q[SEL_CNF];
            SEL_OE:   bus_rdata[PINS-1:0] = ctrl_q[SEL_OE];
            SEL_OUT:  bus_rdata[PINS-1:0] = ctrl_q[SEL_OUT];
            SEL_IN:   bus_rdata[PINS-1:0] = in_q;
            default:  bus_rdata = '0;
        endcase
    end

    assign pad_gpio_sel = ctrl_q[SEL_CNF];
    assign pad_oe       = ctrl_q[SEL_CNF] & ctrl_q[SEL_OE];
    assign pad_out      = ctrl_q[SEL_OUT];

    // R5: one bus write reaches at most one register
    p_one_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({plain_we_v, mask_we_v}));

    // R7: a driver is never enabled on a pin the port does not own
    p_oe_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ~pad_gpio_sel) == '0);

    // R9: a write to the input address touches no control register
    p_input_ro_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == SEL_IN) |=> $stable(pad_out) && $stable(pad_gpio_sel));

endmodule

// File: tb/tb_gpio_port_regs.sv
module tb_gpio_port_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  pad_in = '0;
    logic [7:0]  pad_out, pad_oe, pad_gpio_sel;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    logic [7:0] m_reg [3];

    localparam logic [11:0] PLAIN [4] = '{12'h004, 12'h014, 12'h024, 12'h034};
    localparam logic [11:0] MASKD [3] = '{12'h084, 12'h094, 12'h0A4};

    gpio_port_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_gpio_sel(pad_gpio_sel)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic check_all(input string req);
        logic [31:0] v;
        for (int r = 0; r < 3; r++) begin
            bus_read(PLAIN[r], v);
            chk(req, v, {24'h0, m_reg[r]});
            bus_read(MASKD[r], v);
            chk({req, " R4"}, v, {24'h0, m_reg[r]});
        end
        chk({req, " R6"}, {24'h0, pad_gpio_sel}, {24'h0, m_reg[0]});
        chk({req, " R7"}, {24'h0, pad_oe}, {24'h0, m_reg[0] & m_reg[1]});
        chk({req, " R7"}, {24'h0, pad_out}, {24'h0, m_reg[2]});
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<=150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        for (int r = 0; r < 3; r++) m_reg[r] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check_all("R1");

        // R2: whole-word writes, upper data bits carry junk
        for (int r = 0; r < 3; r++) begin
            for (int x = 0; x < 256; x++) begin
                bus_write(PLAIN[r], {8'hA5, 8'h3C, 8'(x ^ 8'hFF), 8'(x)});
                m_reg[r] = 8'(x);
                bus_read(PLAIN[r], v);
                chk("R2", v, {24'h0, m_reg[r]});
            end
            check_all("R2");
        end

        // R3: masked writes over every mask
        for (int r = 0; r < 3; r++) begin
            for (int mk = 0; mk < 256; mk++) begin
                logic [7:0] val;
                val = 8'((mk * 37) ^ 8'h5A);
                bus_write(MASKD[r], {8'hFF, 8'h00, 8'(mk), val});
                m_reg[r] = (m_reg[r] & ~8'(mk)) | (val & 8'(mk));
                bus_read(MASKD[r], v);
                chk("R3", v, {24'h0, m_reg[r]});
            end
            check_all("R3");
        end

        // R3: zero mask changes nothing
        bus_write(MASKD[1], 32'h0000_00FF);
        check_all("R3 zero mask");

        // R6/R7: patterns of select and enable
        for (int s = 0; s < 16; s++) begin
            bus_write(PLAIN[0], 32'(s * 17));
            m_reg[0] = 8'(s * 17);
            bus_write(PLAIN[1], 32'(8'hF0 ^ 8'(s * 3)));
            m_reg[1] = 8'hF0 ^ 8'(s * 3);
            check_all("R7");
        end

        // R8: input path lag of two edges
        for (int x = 1; x < 256; x++) begin
            logic [7:0] old;
            bus_read(PLAIN[3], v);
            old = v[7:0];
            pad_in = 8'(x);
            @(negedge clk);
            bus_read(PLAIN[3], v);
            chk("R8 one edge", v, {24'h0, old});
            @(negedge clk);
            bus_read(PLAIN[3], v);
            chk("R8 two edges", v, {24'h0, 8'(x)});
        end

        // R9: writes to the input address
        pad_in = 8'h5C;
        repeat (2) @(negedge clk);
        bus_write(PLAIN[3], 32'h0000_FFA3);
        bus_read(PLAIN[3], v);
        chk("R9", v, 32'h0000_005C);
        check_all("R9");

        // R10: addresses outside the map
        bus_write(12'h000, 32'h0000_FFFF);
        bus_write(12'h008, 32'h0000_FFFF);
        bus_write(12'h028, 32'h0000_FF00);
        bus_write(12'h080, 32'h0000_FFFF);
        bus_write(12'h0B4, 32'h0000_FFFF);
        bus_write(12'h104, 32'h0000_FF00);
        check_all("R10");
        bus_read(12'h000, v);  chk("R10 read", v, 32'h0);
        bus_read(12'h0B4, v);  chk("R10 read", v, 32'h0);
        bus_read(12'h024, v);  chk("R5 slot", v, {24'h0, m_reg[2]});

        // R1: reset again clears everything
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int r = 0; r < 3; r++) m_reg[r] = '0;
        @(negedge clk);
        check_all("R1 again");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule